// File: doc/BRIEF.md
# Capture Compare PWM Unit

This unit sits next to a 16-bit free-running timer and an 8-bit period timer. It turns them into one of three services, picked by a 4-bit mode code in its control register. In capture mode it stores the wide timer's value when chosen edges arrive on its input pin. The edge can be every falling edge, every rising edge, or every 4th or 16th rising edge. In compare mode it acts when the wide timer reaches the stored value. It can drive the output pin high, drive it low, raise the interrupt flag only, or also fire a one-cycle special-event strobe. In PWM mode it produces a 10-bit duty output, locked to the period timer's restarts.

Both timers arrive as input buses. The period timer is extended to 10 bits by two sub-count bits and comes with a one-cycle restart strobe. Software reaches four byte registers through a simple address/write-enable port with a combinational read path. Address 0 holds the low byte of the capture/compare value and address 1 the high byte. Address 2 is the control register, and bit 0 of address 3 is the interrupt flag.

Top module: `ccp_unit`

## Requirements
- R1: After reset, the control register reads 0x00, the interrupt flag reads 0, and `ccp_out` and `ccp_trig` are 0.
- R2: Control register (address 2): bits 3:0 are the mode and bits 5:4 are the PWM duty fraction. Bits 7:6 always read 0, so writing 0xFF reads back 0x3F.
- R3: Mode 0101 captures on every rising edge and mode 0100 on every falling edge of `cap_in`. The pin passes through two synchroniser flops, so `tmr_wide` is latched into the capture register at the third rising clock edge after the pin changes. Each capture sets the flag.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge. Earlier edges leave both the register and the flag untouched.
- R5: Any write that changes the mode code clears the edge prescale count. Counting restarts from zero under the new code.
- R6: Mode 1000 drives `ccp_out` high and mode 1001 drives it low on the cycle after `tmr_wide` becomes equal to the capture/compare register. A match that lasts several cycles counts as one event.
- R7: Mode 1010 sets only the flag on a match and leaves the output as it was. Mode 1011 also pulses `ccp_trig` high for exactly one cycle.
- R8: The interrupt flag stays set until software writes 0 to bit 0 of address 3. A capture or compare event in the same cycle wins over the write.
- R9: Any mode code 11xx selects PWM, with a duty of {low byte, control bits 5:4} and a count of {`tmr_period`, `tmr_sub`}. On `period_restart` the output goes high, or stays low when the new duty is 0. It goes low when the count equals the duty.
- R10: The PWM duty is copied into a shadow register only at `period_restart`. A bus write in mid-period has no effect on the current period.
- R11: Mode 0000 holds `ccp_out` low, and a timer match raises no flag and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| tmr_wide | input | 16 | Free-running 16-bit timer value |
| tmr_period | input | 8 | 8-bit period timer value |
| tmr_sub | input | 2 | Sub-count bits that extend the period timer to 10 bits |
| period_restart | input | 1 | One-cycle strobe when the period timer restarts |
| cap_in | input | 1 | Capture input pin (asynchronous) |
| ccp_out | output | 1 | Compare / PWM output pin |
| ccp_irq | output | 1 | Interrupt flag |
| ccp_trig | output | 1 | Special-event strobe |

## Verification
The embedded assertions check the following on every cycle:
- each capture lands the previous cycle's timer value and leaves the flag set;
- a mode write clears the prescale count;
- the special strobe lasts one cycle and comes only from mode 1011;
- the compare pin is low in the off mode;
- the PWM output rises only after a restart.

Only the bench's scenarios can show the rest. That covers which edge of a pulse train is captured and how long the synchroniser delays a capture. It also covers the level each compare action leaves on the pin, the exact count at which the PWM falls, and that a mid-period duty write waits for the next restart.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
    localparam int BUS_W  = 8;
    localparam int FRAC_W = 2;
    localparam int MODE_W = 4;

    localparam logic [1:0] A_LO   = 2'd0;
    localparam logic [1:0] A_HI   = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;
    localparam logic [1:0] A_FLAG = 2'd3;

    localparam logic [MODE_W-1:0] M_OFF      = 4'b0000;
    localparam logic [MODE_W-1:0] M_CAP_FALL = 4'b0100;
    localparam logic [MODE_W-1:0] M_CAP_RISE = 4'b0101;
    localparam logic [MODE_W-1:0] M_CAP_4    = 4'b0110;
    localparam logic [MODE_W-1:0] M_CAP_16   = 4'b0111;
    localparam logic [MODE_W-1:0] M_CMP_SET  = 4'b1000;
    localparam logic [MODE_W-1:0] M_CMP_CLR  = 4'b1001;
    localparam logic [MODE_W-1:0] M_CMP_IRQ  = 4'b1010;
    localparam logic [MODE_W-1:0] M_CMP_TRIG = 4'b1011;

    typedef struct packed {
        logic [FRAC_W-1:0] frac;
        logic [MODE_W-1:0] mode;
    } ctrl_t;

    function automatic logic is_cap(input logic [MODE_W-1:0] m);
        return m[3:2] == 2'b01;
    endfunction

    function automatic logic is_cmp(input logic [MODE_W-1:0] m);
        return m[3:2] == 2'b10;
    endfunction

    function automatic logic is_pwm(input logic [MODE_W-1:0] m);
        return m[3:2] == 2'b11;
    endfunction
endpackage

// File: rtl/ccp_edge_cap.sv
module ccp_edge_cap
    import ccp_pkg::*;
#(
    parameter int SYNC  = 2,
    parameter int DIV_A = 4,
    parameter int DIV_B = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin,
    input  logic [MODE_W-1:0] mode,
    input  logic              mode_chg,
    output logic              cap_evt
);
    localparam int CW = $clog2(DIV_B);

    logic [SYNC:0]   sh;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   target;
    logic            rise, fall, pre_mode;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SYNC-1:0], pin};
    end

    assign rise     = sh[SYNC-1] & ~sh[SYNC];
    assign fall     = ~sh[SYNC-1] & sh[SYNC];
    assign target   = mode[0] ? CW'(DIV_B - 1) : CW'(DIV_A - 1);
    assign pre_mode = (mode == M_CAP_4) || (mode == M_CAP_16);

    always_comb begin
        unique case (mode)
            M_CAP_FALL:        cap_evt = fall;
            M_CAP_RISE:        cap_evt = rise;
            M_CAP_4, M_CAP_16: cap_evt = rise && (cnt == target);
            default:           cap_evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || mode_chg)        cnt <= '0;
        else if (pre_mode && rise)  cnt <= (cnt == target) ? '0 : cnt + 1'b1;
    end

    p_prescale_clear_r5: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> (cnt == '0));
endmodule

// File: rtl/ccp_compare.sv
module ccp_compare
    import ccp_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic [TW-1:0]     tmr,
    input  logic [TW-1:0]     ref_val,
    output logic              cmp_evt,
    output logic              pin_q,
    output logic              trig_q
);
    logic match, match_d;

    assign match   = (tmr == ref_val);
    assign cmp_evt = is_cmp(mode) && match && !match_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_d <= 1'b0;
            pin_q   <= 1'b0;
            trig_q  <= 1'b0;
        end else begin
            match_d <= match;
            trig_q  <= cmp_evt && (mode == M_CMP_TRIG);
            if (mode == M_OFF)                           pin_q <= 1'b0;
            else if (cmp_evt && mode == M_CMP_SET)       pin_q <= 1'b1;
            else if (cmp_evt && mode == M_CMP_CLR)       pin_q <= 1'b0;
        end
    end

    p_trig_single_r7: assert property (@(posedge clk) disable iff (rst)
        trig_q |=> !trig_q);
    p_trig_mode_r7: assert property (@(posedge clk) disable iff (rst)
        trig_q |-> ($past(mode) == M_CMP_TRIG));
    p_off_low_r11: assert property (@(posedge clk) disable iff (rst)
        (mode == M_OFF) |=> !pin_q);
endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
    parameter int DW = 8,
    parameter int FW = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             restart,
    input  logic [DW+FW-1:0] duty_next,
    input  logic [DW+FW-1:0] cnt,
    output logic             pwm_q
);
    logic [DW+FW-1:0] shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            pwm_q  <= 1'b0;
        end else if (!en) begin
            pwm_q  <= 1'b0;
        end else if (restart) begin
            shadow <= duty_next;
            pwm_q  <= (duty_next != '0);
        end else if (cnt == shadow) begin
            pwm_q  <= 1'b0;
        end
    end

    p_rise_on_restart_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_q) |-> $past(restart));
endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
    import ccp_pkg::*;
#(
    parameter int DW = BUS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [2*DW-1:0] tmr_wide,
    input  logic [DW-1:0] tmr_period,
    input  logic [FRAC_W-1:0] tmr_sub,
    input  logic          period_restart,
    input  logic          cap_in,
    output logic          ccp_out,
    output logic          ccp_irq,
    output logic          ccp_trig
);
    localparam int TW = 2 * DW;
    localparam int CTRL_W = $bits(ctrl_t);

    logic [TW-1:0] ccpr;
    ctrl_t         ctrl;
    logic          flag;
    logic          mode_chg, cap_evt, cmp_evt, pin_q, pwm_q;
    logic          wr_lo, wr_hi, wr_ctrl, wr_flag;

    assign wr_lo    = bus_we && bus_addr == A_LO;
    assign wr_hi    = bus_we && bus_addr == A_HI;
    assign wr_ctrl  = bus_we && bus_addr == A_CTRL;
    assign wr_flag  = bus_we && bus_addr == A_FLAG;
    assign mode_chg = wr_ctrl && (bus_wdata[MODE_W-1:0] != ctrl.mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            ccpr <= '0;
            ctrl <= '0;
            flag <= 1'b0;
        end else begin
            if (cap_evt)     ccpr <= tmr_wide;
            else if (wr_lo)  ccpr[DW-1:0]  <= bus_wdata;
            else if (wr_hi)  ccpr[TW-1:DW] <= bus_wdata;
            if (wr_ctrl)     ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (cap_evt || cmp_evt) flag <= 1'b1;
            else if (wr_flag)       flag <= bus_wdata[0];
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_LO:    bus_rdata = ccpr[DW-1:0];
            A_HI:    bus_rdata = ccpr[TW-1:DW];
            A_CTRL:  bus_rdata = {{(DW-CTRL_W){1'b0}}, ctrl};
            default: bus_rdata = {{(DW-1){1'b0}}, flag};
        endcase
    end

    ccp_edge_cap u_cap (
        .clk(clk), .rst(rst), .pin(cap_in), .mode(ctrl.mode),
        .mode_chg(mode_chg), .cap_evt(cap_evt)
    );

    ccp_compare #(.TW(TW)) u_cmp (
        .clk(clk), .rst(rst), .mode(ctrl.mode), .tmr(tmr_wide),
        .ref_val(ccpr), .cmp_evt(cmp_evt), .pin_q(pin_q), .trig_q(ccp_trig)
    );

    ccp_pwm #(.DW(DW), .FW(FRAC_W)) u_pwm (
        .clk(clk), .rst(rst), .en(is_pwm(ctrl.mode)), .restart(period_restart),
        .duty_next({ccpr[DW-1:0], ctrl.frac}), .cnt({tmr_period, tmr_sub}),
        .pwm_q(pwm_q)
    );

    assign ccp_out = is_pwm(ctrl.mode) ? pwm_q : (is_cmp(ctrl.mode) ? pin_q : 1'b0);
    assign ccp_irq = flag;

    p_capture_latch_r3: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> (ccp_irq && ccpr == $past(tmr_wide)));
    p_event_beats_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (cmp_evt && wr_flag) |=> ccp_irq);
endmodule

// File: tb/sim_ccp_unit.sv
module sim_ccp_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] tmr_wide = 16'hFFFF;
    logic [7:0]  tmr_period = '0;
    logic [1:0]  tmr_sub = '0;
    logic        period_restart = 1'b0;
    logic        cap_in = 1'b0;
    logic        ccp_out, ccp_irq, ccp_trig;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ccp_unit u0 (.*);

    typedef struct packed {
        logic [3:0]  mode;
        logic [15:0] ref_v;
        logic [15:0] tmr;
        logic        out;
        logic        irq;
        logic        trig;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'b1000, 16'h1234, 16'h1234, 1'b1, 1'b1, 1'b0},
        '{4'b1001, 16'h1234, 16'h1234, 1'b0, 1'b1, 1'b0},
        '{4'b1000, 16'h00A5, 16'h00A4, 1'b0, 1'b0, 1'b0},
        '{4'b1000, 16'h00A5, 16'h00A5, 1'b1, 1'b1, 1'b0},
        '{4'b1010, 16'hBEEF, 16'hBEEF, 1'b1, 1'b1, 1'b0},
        '{4'b1011, 16'h4321, 16'h4321, 1'b1, 1'b1, 1'b1},
        '{4'b0000, 16'h5555, 16'h5555, 1'b0, 1'b0, 1'b0},
        '{4'b1001, 16'h8000, 16'h8000, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(2'd0, lo);
        rd(2'd1, hi);
        v = {hi, lo};
    endtask

    // rising edge sees v, falling edge sees v+1
    task automatic pulse(input logic [15:0] v);
        @(negedge clk);
        tmr_wide = v; cap_in = 1'b1;
        repeat (5) @(negedge clk);
        tmr_wide = v + 16'd1; cap_in = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic pwm_run(input int last, input int fall_at, input string req);
        for (int c = 1; c <= last; c++) begin
            tmr_period = 8'(c >> 2); tmr_sub = 2'(c);
            @(negedge clk);
            chk(req, 16'(ccp_out), 16'(c < fall_at));
        end
    endtask

    initial begin
        logic [7:0]  b;
        logic [15:0] w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(2'd2, b); chk("R1 ctrl", 16'(b), 16'h00);
        rd(2'd3, b); chk("R1 flag", 16'(b), 16'h00);
        chk("R1 out", 16'(ccp_out), 16'd0);
        chk("R1 trig", 16'(ccp_trig), 16'd0);

        // compare table: R6 R7 R11 R8
        for (int i = 0; i < 8; i++) begin
            tmr_wide = 16'hFFFF;
            wr(2'd3, 8'h00);
            wr(2'd0, VECS[i].ref_v[7:0]);
            wr(2'd1, VECS[i].ref_v[15:8]);
            wr(2'd2, {4'h0, VECS[i].mode});
            tmr_wide = VECS[i].tmr;
            @(negedge clk);
            chk("R6/R7/R11 out", 16'(ccp_out), 16'(VECS[i].out));
            chk("R7/R8/R11 irq", 16'(ccp_irq), 16'(VECS[i].irq));
            chk("R7 trig", 16'(ccp_trig), 16'(VECS[i].trig));
            @(negedge clk);
            chk("R7 trig one cycle", 16'(ccp_trig), 16'd0);
            chk("R6 single event out", 16'(ccp_out), 16'(VECS[i].out));
        end

        // R8: flag holds until written 0
        repeat (4) @(negedge clk);
        chk("R8 flag held", 16'(ccp_irq), 16'd1);
        wr(2'd3, 8'h00);
        chk("R8 flag cleared", 16'(ccp_irq), 16'd0);

        // R3 rising capture
        tmr_wide = 16'h0000;
        wr(2'd2, 8'h05);
        pulse(16'h0101);
        rd16(w); chk("R3 rising capture", w, 16'h0101);
        chk("R3 flag", 16'(ccp_irq), 16'd1);
        // R3 falling capture
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h04);
        pulse(16'h0200);
        rd16(w); chk("R3 falling capture", w, 16'h0201);

        // R3 synchroniser latency: captured at third edge
        wr(2'd2, 8'h05);
        @(negedge clk);
        tmr_wide = 16'h0A00; cap_in = 1'b1;
        @(negedge clk); tmr_wide = 16'h0A01;
        @(negedge clk); tmr_wide = 16'h0A02;
        @(negedge clk); tmr_wide = 16'h0A03;
        @(negedge clk);
        cap_in = 1'b0;
        rd16(w); chk("R3 latency", w, 16'h0A02);
        repeat (5) @(negedge clk);

        // R4 every 4th
        wr(2'd2, 8'h06);
        wr(2'd3, 8'h00);
        for (int k = 0; k < 3; k++) pulse(16'h0010 + 16'(k));
        chk("R4 no capture before 4th", 16'(ccp_irq), 16'd0);
        pulse(16'h0013);
        rd16(w); chk("R4 4th edge", w, 16'h0013);

        // R5 mode change clears prescale
        wr(2'd3, 8'h00);
        pulse(16'h0020); pulse(16'h0022);
        wr(2'd2, 8'h07);
        wr(2'd2, 8'h06);
        for (int k = 0; k < 3; k++) pulse(16'h0030 + 16'(k));
        chk("R5 count restarted", 16'(ccp_irq), 16'd0);
        pulse(16'h0033);
        rd16(w); chk("R5 capture after restart", w, 16'h0033);

        // R4 every 16th
        wr(2'd2, 8'h07);
        wr(2'd3, 8'h00);
        for (int k = 0; k < 15; k++) pulse(16'h0040 + 16'(k));
        chk("R4 no capture before 16th", 16'(ccp_irq), 16'd0);
        pulse(16'h004F);
        rd16(w); chk("R4 16th edge", w, 16'h004F);

        // R2 unused bits
        wr(2'd2, 8'hFF);
        rd(2'd2, b); chk("R2 ctrl readback", 16'(b), 16'h3F);

        // R9 PWM, duty = {0x02, 01} = 9
        wr(2'd0, 8'h02);
        wr(2'd2, 8'h1C);
        tmr_period = '0; tmr_sub = '0; period_restart = 1'b1;
        @(negedge clk);
        period_restart = 1'b0;
        chk("R9 high after restart", 16'(ccp_out), 16'd1);
        // R10 mid-period write does not move this period's fall
        wr(2'd0, 8'h10);
        chk("R10 still high", 16'(ccp_out), 16'd1);
        pwm_run(15, 9, "R9/R10 duty 9");
        // next restart picks up duty {0x10,01} = 65
        tmr_period = '0; tmr_sub = '0; period_restart = 1'b1;
        @(negedge clk);
        period_restart = 1'b0;
        pwm_run(70, 65, "R10 new duty 65");
        // duty 0 stays low
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h0C);
        tmr_period = 8'h40; period_restart = 1'b1;
        @(negedge clk);
        period_restart = 1'b0;
        chk("R9 zero duty low", 16'(ccp_out), 16'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule